// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Direction Arbiter

This block decides which way data flows over a set of bidirectional, idle-high lines that join a host side to a card side. A separate arbiter serves each line. It watches the sampled level on both sides of the line. The side that goes low first becomes the master. After a programmable number of clock cycles the arbiter copies that low level to the other side, the slave, by enabling the slave's pull-down. While a master holds the line, a low seen on the slave side is ignored. This matters because the arbiter's own pull-down makes the slave low.

When the master lets go, the slave's pull-down is released and an active pull-up (booster) on the slave side is enabled for the same number of cycles. The line then returns to idle. If something external still holds a side low after the booster window, that is a conflict. The arbiter then drives nothing until both sides read high again. A state where both sides are high always leads back to idle, so the lines cannot latch low.

The bank holds one arbiter for each of the data, auxiliary-1 and auxiliary-2 lines (`NUM_LINES` = 3). Bit 0 of every vector is the data line. The transfer delay `DELAY_CYC` is set in clock cycles.

Top module: `lax_bank`

## Requirements
- R1: After reset all pull-down and booster enables are 0. Until a line has read high on both sides at one clock edge, that line drives nothing.
- R2: In idle, a low host level sampled at clock edge k makes the host side master. The card pull-down is then asserted from edge k+DELAY_CYC on and stays asserted while the host stays low. The host pull-down stays 0 throughout.
- R3: In idle, a low card level with a high host level is the mirror case of R2. The card side becomes master and the host pull-down is asserted DELAY_CYC cycles later.
- R4: When both sides are sampled low at the same idle edge, the host side becomes master (default tie rule).
- R5: While a master is held, lows on the slave side do not change the master or the timing. At no time are both pull-downs asserted together.
- R6: If the master returns high before the DELAY_CYC cycles have run, nothing is transferred. The line returns to idle if both sides read high; otherwise it enters the R8 recovery wait.
- R7: When the master reads high while the slave is pulled down, the slave pull-down drops and the slave booster is asserted for exactly DELAY_CYC cycles. A pull-down and the booster of the same side are never asserted together.
- R8: If a side is still low when the booster window ends, the line drives nothing and enables no booster until both sides read high.
- R9: When a recovering line reads high on both sides, it is idle at the next edge, and the next low elects a master as in R2/R3.
- R10: The lines are independent: activity on one line never changes the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_lvl | input | NUM_LINES | Sampled host-side level per line (1 = high) |
| card_lvl | input | NUM_LINES | Sampled card-side level per line (1 = high) |
| host_pull | output | NUM_LINES | Host-side pull-down enable per line |
| card_pull | output | NUM_LINES | Card-side pull-down enable per line |
| host_boost | output | NUM_LINES | Host-side active pull-up enable per line |
| card_boost | output | NUM_LINES | Card-side active pull-up enable per line |

## Verification
The bench wires each side as a wired-AND of the arbiter's pull-down and an external driver. This lets the arbiter's own drive feed back into its inputs, as it would on a real pad. The patterns used are:
- long host-first and card-first lows, which show whether the direction and the delay count are correct;
- a same-edge low on both sides, which exposes the tie rule;
- slave-side pulses during a transfer, which show whether the lockout holds;
- master pulses shorter than the delay, which separate an aborted transfer from a completed one;
- an external low held past the booster window, which exercises conflict recovery.

Several lines run different patterns at once, so any coupling between lines shows up.

// File: rtl/lax_pkg.sv
package lax_pkg;

   typedef enum logic [2:0] {
      LX_SETTLE = 3'd0,   // wait until both sides read high
      LX_IDLE   = 3'd1,
      LX_WAIT   = 3'd2,   // master chosen, transfer delay running
      LX_DRIVE  = 3'd3,   // slave pulled low
      LX_BOOST  = 3'd4    // slave actively pulled up
   } lx_phase_e;

   typedef enum logic {
      SIDE_HOST = 1'b0,
      SIDE_CARD = 1'b1
   } lx_side_e;

   function automatic int unsigned lx_cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/lax_timer.sv
module lax_timer #(
   parameter int unsigned LIMIT = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic last
);
   import lax_pkg::*;

   localparam int unsigned CNT_W = lx_cnt_width(LIMIT);
   localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(LIMIT - 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("lax_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (clear)           cnt <= '0;
      else if (run && !last)    cnt <= cnt + 1'b1;
   end

   assign last = (cnt == LAST_VAL);

endmodule

// File: rtl/lax_line.sv
module lax_line #(
   parameter int unsigned DELAY_CYC = 5,
   parameter bit          TIE_HOST  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic host_lvl,
   input  logic card_lvl,
   output logic host_pull,
   output logic card_pull,
   output logic host_boost,
   output logic card_boost
);
   import lax_pkg::*;

   lx_phase_e phase, phase_nx;
   lx_side_e  master, master_nx;
   logic      tmr_last, tmr_clear, tmr_run;
   logic      master_high, both_high;
   logic      any_low;
   lx_side_e  winner;

   // election of the first low side; tie rule picked by parameter
   assign any_low = !host_lvl || !card_lvl;
   generate
      if (TIE_HOST) begin : g_tie_host
         assign winner = !host_lvl ? SIDE_HOST : SIDE_CARD;
      end else begin : g_tie_card
         assign winner = !card_lvl ? SIDE_CARD : SIDE_HOST;
      end
   endgenerate

   assign master_high = (master == SIDE_HOST) ? host_lvl : card_lvl;
   assign both_high   = host_lvl && card_lvl;

   lax_timer #(.LIMIT(DELAY_CYC)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (tmr_clear),
      .run   (tmr_run),
      .last  (tmr_last)
   );

   assign tmr_run   = (phase == LX_WAIT) || (phase == LX_BOOST);
   assign tmr_clear = !tmr_run;

   always_comb begin
      phase_nx  = phase;
      master_nx = master;
      unique case (phase)
         LX_SETTLE: if (both_high) phase_nx = LX_IDLE;
         LX_IDLE: begin
            if (any_low) begin
               phase_nx  = LX_WAIT;
               master_nx = winner;
            end
         end
         LX_WAIT: begin
            if (master_high)   phase_nx = both_high ? LX_IDLE : LX_SETTLE;
            else if (tmr_last) phase_nx = LX_DRIVE;
         end
         LX_DRIVE: if (master_high) phase_nx = LX_BOOST;
         LX_BOOST: if (tmr_last) phase_nx = both_high ? LX_IDLE : LX_SETTLE;
         default:  phase_nx = LX_SETTLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= LX_SETTLE;
         master <= SIDE_HOST;
      end else begin
         phase  <= phase_nx;
         master <= master_nx;
      end
   end

   assign card_pull  = (phase == LX_DRIVE) && (master == SIDE_HOST);
   assign host_pull  = (phase == LX_DRIVE) && (master == SIDE_CARD);
   assign card_boost = (phase == LX_BOOST) && (master == SIDE_HOST);
   assign host_boost = (phase == LX_BOOST) && (master == SIDE_CARD);

   AST_SINGLE_PULL: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_pull && card_pull)); // R5
   AST_CARD_PULL_BOOST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(card_pull && card_boost)); // R7
   AST_HOST_PULL_BOOST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_pull && host_boost)); // R7
   AST_CARD_BOOST_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(card_pull) |-> card_boost); // R7
   AST_HOST_BOOST_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_pull) |-> host_boost); // R7
   AST_CARD_PULL_FROM_HOST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_pull) |-> $past(!host_lvl)); // R2
   AST_HOST_PULL_FROM_CARD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_pull) |-> $past(!card_lvl)); // R3
   AST_SETTLE_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == LX_SETTLE) |=> !(host_pull || card_pull || host_boost || card_boost)); // R8
   AST_ANTI_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == LX_SETTLE && host_lvl && card_lvl) |=> (phase == LX_IDLE)); // R9

endmodule

// File: rtl/lax_bank.sv
module lax_bank #(
   parameter int unsigned NUM_LINES = 3,
   parameter int unsigned DELAY_CYC = 5,
   parameter bit          TIE_HOST  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] host_lvl,
   input  logic [NUM_LINES-1:0] card_lvl,
   output logic [NUM_LINES-1:0] host_pull,
   output logic [NUM_LINES-1:0] card_pull,
   output logic [NUM_LINES-1:0] host_boost,
   output logic [NUM_LINES-1:0] card_boost
);

   generate
      if (NUM_LINES < 1) begin : g_bad_lines
         $error("lax_bank: NUM_LINES must be at least 1");
      end
      if (DELAY_CYC < 1) begin : g_bad_delay
         $error("lax_bank: DELAY_CYC must be at least 1");
      end
   endgenerate

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      lax_line #(
         .DELAY_CYC (DELAY_CYC),
         .TIE_HOST  (TIE_HOST)
      ) i_line (
         .clk        (clk),
         .rst_n      (rst_n),
         .host_lvl   (host_lvl[g]),
         .card_lvl   (card_lvl[g]),
         .host_pull  (host_pull[g]),
         .card_pull  (card_pull[g]),
         .host_boost (host_boost[g]),
         .card_boost (card_boost[g])
      );
   end

endmodule

// File: tb/test_lax_bank.sv
module test_lax_bank;
   localparam int NL = 3;
   localparam int D  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NL-1:0] host_ext = '0, card_ext = '0;   // 1 = external low
   logic [NL-1:0] host_lvl, card_lvl;
   logic [NL-1:0] host_pull, card_pull, host_boost, card_boost;

   always #5 clk = ~clk;

   // wired-AND pads
   assign host_lvl = ~(host_pull | host_ext);
   assign card_lvl = ~(card_pull | card_ext);

   lax_bank #(.NUM_LINES(NL), .DELAY_CYC(D)) i_lax_bank (
      .clk(clk), .rst_n(rst_n),
      .host_lvl(host_lvl), .card_lvl(card_lvl),
      .host_pull(host_pull), .card_pull(card_pull),
      .host_boost(host_boost), .card_boost(card_boost)
   );

   // behavioural reference: mode 0 recovering, 1 idle, 2 delaying, 3 copying, 4 boosting
   int  m_mode [NL];
   int  m_owner[NL];   // 0 host leads, 1 card leads
   int  m_left [NL];   // cycles remaining in timed modes
   int  n_chk = 0, n_fail = 0;
   bit  finished = 0;
   string tag = "R1";

   initial for (int l = 0; l < NL; l++) begin
      m_mode[l] = 0; m_owner[l] = 0; m_left[l] = 0;
   end

   always @(posedge clk) begin
      for (int l = 0; l < NL; l++) begin
         bit h, c, lead_high;
         h = host_lvl[l]; c = card_lvl[l];
         lead_high = (m_owner[l] == 0) ? h : c;
         if (!rst_n) m_mode[l] <= 0;
         else case (m_mode[l])
            0: if (h && c) m_mode[l] <= 1;
            1: if (!h || !c) begin
                  m_mode[l] <= 2; m_owner[l] <= (!h) ? 0 : 1; m_left[l] <= D;
               end
            2: if (lead_high) m_mode[l] <= (h && c) ? 1 : 0;
               else if (m_left[l] == 1) m_mode[l] <= 3;
               else m_left[l] <= m_left[l] - 1;
            3: if (lead_high) begin m_mode[l] <= 4; m_left[l] <= D; end
            default: if (m_left[l] == 1) m_mode[l] <= (h && c) ? 1 : 0;
                     else m_left[l] <= m_left[l] - 1;
         endcase
      end
   end

   always @(negedge clk) if (!finished) begin
      for (int l = 0; l < NL; l++) begin
         logic [3:0] got, exp;
         got = {host_pull[l], card_pull[l], host_boost[l], card_boost[l]};
         exp = {m_mode[l] == 3 && m_owner[l] == 1, m_mode[l] == 3 && m_owner[l] == 0,
                m_mode[l] == 4 && m_owner[l] == 1, m_mode[l] == 4 && m_owner[l] == 0};
         n_chk++;
         if (got !== exp) begin
            n_fail++;
            $display("FAIL %s line%0d {hpull,cpull,hboost,cboost} got %b exp %b at %0t",
                     tag, l, got, exp, $time);
         end
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // directed point check, independent of the per-cycle model
   task automatic point(input string t, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s point check got %b exp %b at %0t", t, got, exp, $time);
      end
   endtask

   task automatic finish_run();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: reset with line 0 host held low -> recovering, no drive
      tag = "R1";
      host_ext[0] = 1'b1;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(D + 3);
      point("R1", card_pull[0], 1'b0);
      tag = "R9"; host_ext[0] = 1'b0;
      wait_cyc(3);

      // R2: host-first low on line 0; card pull appears D cycles after first low edge
      tag = "R2"; host_ext[0] = 1'b1;
      wait_cyc(D);
      point("R2", card_pull[0], 1'b0);
      wait_cyc(1);
      point("R2", card_pull[0], 1'b1);
      wait_cyc(8);
      tag = "R7"; host_ext[0] = 1'b0;
      wait_cyc(1);
      point("R7", card_boost[0], 1'b1);
      wait_cyc(D + 2);
      point("R7", card_boost[0], 1'b0);

      // R3: card-first low on line 1
      tag = "R3"; card_ext[1] = 1'b1;
      wait_cyc(D + 1);
      point("R3", host_pull[1], 1'b1);
      wait_cyc(4); card_ext[1] = 1'b0;
      wait_cyc(D + 3);

      // R4: simultaneous low on line 2 -> host leads
      tag = "R4"; host_ext[2] = 1'b1; card_ext[2] = 1'b1;
      wait_cyc(D + 1);
      point("R4", card_pull[2], 1'b1);
      point("R4", host_pull[2], 1'b0);
      card_ext[2] = 1'b0; wait_cyc(2); host_ext[2] = 1'b0;
      wait_cyc(D + 3);

      // R5: slave pulses while host leads on line 0
      tag = "R5"; host_ext[0] = 1'b1;
      wait_cyc(2); card_ext[0] = 1'b1; wait_cyc(1); card_ext[0] = 1'b0;
      wait_cyc(D); card_ext[0] = 1'b1; wait_cyc(2); card_ext[0] = 1'b0;
      point("R5", host_pull[0], 1'b0);
      wait_cyc(3); host_ext[0] = 1'b0;
      wait_cyc(D + 3);

      // R6: short master pulse, no transfer
      tag = "R6"; host_ext[1] = 1'b1; wait_cyc(2); host_ext[1] = 1'b0;
      wait_cyc(D + 2);
      point("R6", card_pull[1], 1'b0);

      // R8 then R9: external card low persists past booster window on line 0
      tag = "R8"; host_ext[0] = 1'b1; wait_cyc(D + 2);
      card_ext[0] = 1'b1; wait_cyc(2); host_ext[0] = 1'b0;
      wait_cyc(D + 6);
      point("R8", host_pull[0] | card_pull[0] | card_boost[0], 1'b0);
      tag = "R9"; card_ext[0] = 1'b0; wait_cyc(2);
      host_ext[0] = 1'b1; wait_cyc(D + 1);
      point("R9", card_pull[0], 1'b1);
      host_ext[0] = 1'b0; wait_cyc(D + 3);

      // R10: concurrent different patterns on all lines, fast toggling
      tag = "R10";
      for (int k = 0; k < 40; k++) begin
         host_ext[0] = (k % 9) < 6;
         card_ext[1] = (k % 13) < 8;
         host_ext[2] = (k % 4) < 1;
         card_ext[2] = (k % 7) == 3;
         wait_cyc(1);
      end
      host_ext = '0; card_ext = '0;
      wait_cyc(2 * D + 4);
      point("R10", |{host_pull, card_pull, host_boost, card_boost}, 1'b0);

      finish_run();
   end

endmodule